// File: doc/BRIEF.md
# Warm/Cold Reset Sequencer

This block decides how a small processor subsystem leaves reset. It watches an active-low reset pad and a reset-mode input. A short low on the pad is ignored. A low that lasts two clocks, with the mode input high, starts a clocked warm sequence. A low on the pad while the mode input is low goes through a clockless cold path instead. The power-on input always takes the cold path.

The warm sequence is a fixed timeline. First comes a settle window. In it the block asks the core to drop pending hold states and asks the bus interface to abort any external cycle. The settle window ends early once the bus interface reports that its current access has finished. Next comes a 512-clock internal phase. During that phase the block can pull its own reset pad low, but only if software armed that option beforehand. The block then releases the pad and samples it, and waits for as long as the pad stays low.

Both the warm and the cold path end with a configuration-latch strobe. It fires a fixed number of clocks after the pad is seen high, and that number depends on the clock-source setting. The internal reset drops on the next clock edge.

Top module: `rstseq_top`

## Requirements
- R1: With `mode_hi` high, a warm sequence starts only when `ext_rst_n` is sampled low on two rising clock edges in a row. A low lasting a single clock leaves every reset output inactive.
- R2: `int_rst`=1, `rst_out_n`=0 and `io_tristate`=1 become visible right after the second of those edges. They are still inactive after the first edge.
- R3: `hold_cancel` and `bus_abort` are high together for a settle window of `SETTLE_MAX`=6 clocks. If `access_done` is already high, the window is 1 clock, because it ends in the first clock where `access_done` is seen high.
- R4: The internal phase lasts exactly 512 clocks. If the pad is high when that phase ends and `access_done` stays low, `int_rst` is high for 6+512+1+N clocks in total. N is defined in R8.
- R5: `pin_pull_low` is high for exactly the 512 clocks of the internal phase, but only if `bidir_en` was 1 when the sequence was recognised. Otherwise it stays low for the whole sequence.
- R6: If the pad is still low when the internal phase ends, all reset outputs stay asserted until the pad goes high. `cfg_latch` then pulses on the N-th clock after the edge that first sees the pad high.
- R7: If `ext_rst_n` is low while `mode_hi` is low, `int_rst` rises at once, with no clock edge needed. If `mode_hi` drops while the block is pulling the pad, the pull is released at once. After the cold cause goes away, release passes through a two-flop synchroniser, and `cfg_latch` pulses N+1 clocks after the cause clears.
- R8: N is 3 when `prescale_bypass`=1 and 4 when it is 0. `cfg_latch` is high for one clock per sequence, and `int_rst` falls at the next rising edge.
- R9: While idle, a pulse on `bidir_arm_wr` sets `bidir_en` to 1. Any reset sequence clears it: warm recognition, the cold path, or power-on.
- R10: While `por_n` is low, `int_rst`=1, `rst_out_n`=0, `io_tristate`=1, `pin_pull_low`=0 and `bidir_en`=0, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | Level seen on the reset pad, active low |
| mode_hi | input | 1 | High allows a warm sequence; low forces the cold path |
| prescale_bypass | input | 1 | 1: prescaler on with the PLL bypassed (N=3); 0: N=4 |
| access_done | input | 1 | Bus interface reports that its current internal access has finished |
| bidir_arm_wr | input | 1 | Software write pulse that arms the pad pull-down |
| int_rst | output | 1 | Internal reset, active high |
| rst_out_n | output | 1 | Reset output, active low |
| io_tristate | output | 1 | Puts the I/O pins in high impedance |
| hold_cancel | output | 1 | Asks the core to cancel pending hold states |
| bus_abort | output | 1 | Asks the bus interface to abort the external cycle |
| pin_pull_low | output | 1 | Drives the reset pad low |
| cfg_latch | output | 1 | One-clock configuration-latch strobe |
| bidir_en | output | 1 | Pad pull-down armed |

## Verification
The warm timeline is tried four ways: with the pad released early and the pull-down unarmed, with the pull-down armed, with `access_done` held high, and with the pad held low well past the internal phase. Together these separate the settle length, the internal-phase length, the effect of arming and the stretch of the hold. A one-clock glitch is applied to show that the recognition filter rejects it. The cold path is tried in three ways: from power-on, from a low pad with `mode_hi` low, and from `mode_hi` dropping during the pull. These show that assertion needs no clock, that release goes through the synchroniser, and that the pull is dropped at once. Both `prescale_bypass` settings are used so that the two strobe delays can be told apart.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DETECT, ST_SETTLE, ST_INTERNAL, ST_EXTEND, ST_RELEASE
  } rseq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Release synchroniser: output goes high STAGES clocks after arst_n rises.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_ok
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rel_ok = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_counter.sv
`timescale 1ns/1ps
// Shared phase counter with explicit clear and enable.
module rstseq_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rstseq_fsm.sv
`timescale 1ns/1ps
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int INTERNAL_CYCLES = 512,
  parameter int SETTLE_MAX      = 6,
  parameter int LATCH_FAST      = 3,
  parameter int LATCH_SLOW      = 4,
  parameter int CNT_W           = 9
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pin_n,
  input  logic             mode_hi,
  input  logic             prescale_bypass,
  input  logic             access_done,
  input  logic             bidir_arm_wr,
  input  logic             rel_ok,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             int_rst,
  output logic             rst_out_n,
  output logic             io_tristate,
  output logic             hold_cancel,
  output logic             bus_abort,
  output logic             pin_pull_low,
  output logic             cfg_latch,
  output logic             bidir_en
);
  localparam logic [CNT_W-1:0] SettleLast = CNT_W'(SETTLE_MAX - 1);
  localparam logic [CNT_W-1:0] IntLast    = CNT_W'(INTERNAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] FastLast   = CNT_W'(LATCH_FAST - 1);
  localparam logic [CNT_W-1:0] SlowLast   = CNT_W'(LATCH_SLOW - 1);

  rseq_state_e state_q, state_d;
  logic        armed_q, armed_d;
  logic        bidir_q, bidir_d;
  logic        latch_d;
  logic        in_rst;
  logic [CNT_W-1:0] lat_last;

  assign lat_last = prescale_bypass ? FastLast : SlowLast;

  // Next-state process
  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    bidir_d = bidir_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    latch_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (bidir_arm_wr) bidir_d = 1'b1;
        if (!pin_n) state_d = ST_DETECT;
      end
      ST_DETECT: begin
        cnt_clr = 1'b1;
        if (!pin_n) begin
          state_d = ST_SETTLE;
          armed_d = bidir_q;
          bidir_d = 1'b0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (access_done || cnt == SettleLast) begin
          state_d = ST_INTERNAL;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_INTERNAL: begin
        if (cnt == IntLast) begin
          state_d = ST_EXTEND;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_EXTEND: begin
        cnt_clr = 1'b1;
        if (pin_n) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (rel_ok && pin_n) begin
          if (cnt == lat_last) begin
            latch_d = 1'b1;
            state_d = ST_IDLE;
            cnt_clr = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end else begin
          cnt_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_RELEASE;
      armed_q <= 1'b0;
      bidir_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      bidir_q <= bidir_d;
    end
  end

  assign in_rst       = (state_q == ST_SETTLE) || (state_q == ST_INTERNAL) ||
                        (state_q == ST_EXTEND) || (state_q == ST_RELEASE);
  assign int_rst      = in_rst;
  assign rst_out_n    = !in_rst;
  assign io_tristate  = in_rst;
  assign hold_cancel  = (state_q == ST_SETTLE);
  assign bus_abort    = (state_q == ST_SETTLE);
  assign pin_pull_low = (state_q == ST_INTERNAL) && armed_q && mode_hi;
  assign cfg_latch    = latch_d;
  assign bidir_en     = bidir_q;

  // R1: settle is entered only from a second low sample
  a_r1_two_lows: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_SETTLE && $past(state_q) != ST_SETTLE) |->
      ($past(state_q) == ST_DETECT && !$past(pin_n)));
  // R2: settle requests come only with the pins already in reset
  a_r2_settle_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    hold_cancel |-> (io_tristate && !rst_out_n));
  // R3: the settle counter never passes its bound
  a_r3_settle_bound: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_SETTLE) |-> (cnt < CNT_W'(SETTLE_MAX)));
  // R5: the pad is pulled only while reset is asserted
  a_r5_pull_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    pin_pull_low |-> (int_rst && !rst_out_n));
  // R6: a low pad keeps the sequence held
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_EXTEND && !pin_n) |=> (state_q == ST_EXTEND));
  // R8: the strobe is a single-clock pulse
  a_r8_latch_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    cfg_latch |=> !cfg_latch);
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top #(
  parameter int INTERNAL_CYCLES = 512,
  parameter int SETTLE_MAX      = 6,
  parameter int LATCH_FAST      = 3,
  parameter int LATCH_SLOW      = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic mode_hi,
  input  logic prescale_bypass,
  input  logic access_done,
  input  logic bidir_arm_wr,
  output logic int_rst,
  output logic rst_out_n,
  output logic io_tristate,
  output logic hold_cancel,
  output logic bus_abort,
  output logic pin_pull_low,
  output logic cfg_latch,
  output logic bidir_en
);
  localparam int CNT_W = $clog2(INTERNAL_CYCLES);

  logic             arst_n;
  logic             rel_ok;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;

  // Cold path: power-on, or a low pad while warm mode is not allowed
  assign arst_n = por_n && (ext_rst_n || mode_hi);

  rstseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .arst_n(arst_n), .rel_ok(rel_ok)
  );

  rstseq_counter #(.W(CNT_W)) cnt_i (
    .clk(clk), .arst_n(arst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  rstseq_fsm #(
    .INTERNAL_CYCLES(INTERNAL_CYCLES), .SETTLE_MAX(SETTLE_MAX),
    .LATCH_FAST(LATCH_FAST), .LATCH_SLOW(LATCH_SLOW), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .arst_n(arst_n), .pin_n(ext_rst_n), .mode_hi(mode_hi),
    .prescale_bypass(prescale_bypass), .access_done(access_done),
    .bidir_arm_wr(bidir_arm_wr), .rel_ok(rel_ok), .cnt(cnt),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .int_rst(int_rst),
    .rst_out_n(rst_out_n), .io_tristate(io_tristate),
    .hold_cancel(hold_cancel), .bus_abort(bus_abort),
    .pin_pull_low(pin_pull_low), .cfg_latch(cfg_latch), .bidir_en(bidir_en)
  );
endmodule

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;
  logic clk = 1'b0;
  logic por_n, pin_drv, mode_hi, prescale_bypass, access_done, bidir_arm_wr;
  logic ext_rst_n;
  logic int_rst, rst_out_n, io_tristate, hold_cancel, bus_abort;
  logic pin_pull_low, cfg_latch, bidir_en;
  int   n_tests = 0;
  int   n_fail  = 0;
  int   c_rst, c_hold, c_abort, c_pull, c_latch;
  logic mon_on = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  // Wired-AND reset pad: board driver and the block's own pull-down
  assign ext_rst_n = pin_drv && !pin_pull_low;

  rstseq_top dut_i (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .mode_hi(mode_hi),
    .prescale_bypass(prescale_bypass), .access_done(access_done),
    .bidir_arm_wr(bidir_arm_wr), .int_rst(int_rst), .rst_out_n(rst_out_n),
    .io_tristate(io_tristate), .hold_cancel(hold_cancel), .bus_abort(bus_abort),
    .pin_pull_low(pin_pull_low), .cfg_latch(cfg_latch), .bidir_en(bidir_en)
  );

  always @(negedge clk) begin
    if (mon_on) begin
      if (int_rst)      c_rst++;
      if (hold_cancel)  c_hold++;
      if (bus_abort)    c_abort++;
      if (pin_pull_low) c_pull++;
      if (cfg_latch)    c_latch++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    c_rst = 0; c_hold = 0; c_abort = 0; c_pull = 0; c_latch = 0;
  endtask

  // Wait at negedges until cfg_latch is seen; k counts the negedges
  task automatic wait_latch(output int k);
    k = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      k++;
      if (cfg_latch) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!int_rst) break;
      @(negedge clk);
    end
  endtask

  task automatic t_por();
    int k;
    #3 por_n = 1'b0;
    #2;
    chk(int_rst && !rst_out_n && io_tristate && !pin_pull_low && !bidir_en,
        "R10 por outputs", int_rst, 1);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    wait_latch(k);
    chk(k == 4, "R7 por release through sync, N=3", k, 4);
    @(negedge clk);
    chk(!int_rst, "R8 int_rst falls after strobe", int_rst, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    clear_stats(); mon_on = 1'b1;
    pin_drv = 1'b0;
    @(negedge clk);
    pin_drv = 1'b1;
    repeat (10) @(negedge clk);
    mon_on = 1'b0;
    chk(c_rst == 0, "R1 one-clock low ignored", c_rst, 0);
  endtask

  task automatic t_warm(input bit arm, input bit acc, input bit fast);
    int n;
    n = fast ? 3 : 4;
    prescale_bypass = fast;
    access_done = acc;
    @(negedge clk);
    if (arm) begin
      bidir_arm_wr = 1'b1;
      @(negedge clk);
      bidir_arm_wr = 1'b0;
      chk(bidir_en, "R9 arm sets bidir_en", bidir_en, 1);
    end
    clear_stats(); mon_on = 1'b1;
    pin_drv = 1'b0;
    @(negedge clk);
    chk(!int_rst, "R2 not asserted after first low edge", int_rst, 0);
    @(negedge clk);
    chk(int_rst && !rst_out_n && io_tristate, "R2 asserted after second edge", int_rst, 1);
    chk(!bidir_en, "R9 recognition clears bidir_en", bidir_en, 0);
    pin_drv = 1'b1;
    wait_idle();
    mon_on = 1'b0;
    chk(c_hold == (acc ? 1 : 6), "R3 hold_cancel length", c_hold, acc ? 1 : 6);
    chk(c_abort == (acc ? 1 : 6), "R3 bus_abort length", c_abort, acc ? 1 : 6);
    chk(c_pull == (arm ? 512 : 0), "R5 pull-down length", c_pull, arm ? 512 : 0);
    chk(c_rst == (acc ? 1 : 6) + 512 + 1 + n, "R4 total reset length",
        c_rst, (acc ? 1 : 6) + 512 + 1 + n);
    chk(c_latch == 1, "R8 single strobe", c_latch, 1);
    access_done = 1'b0;
  endtask

  task automatic t_extend();
    int k;
    prescale_bypass = 1'b0;
    @(negedge clk);
    pin_drv = 1'b0;
    repeat (700) @(negedge clk);
    chk(int_rst && !rst_out_n, "R6 held while pad low", int_rst, 1);
    pin_drv = 1'b1;
    wait_latch(k);
    chk(k == 4, "R6 R8 strobe N=4 after pad high", k, 4);
    @(negedge clk);
    chk(!int_rst, "R8 int_rst falls after strobe", int_rst, 0);
  endtask

  task automatic t_cold();
    int k;
    prescale_bypass = 1'b1;
    @(negedge clk);
    bidir_arm_wr = 1'b1;
    @(negedge clk);
    bidir_arm_wr = 1'b0;
    mode_hi = 1'b0;
    #2 pin_drv = 1'b0;
    #1;
    chk(int_rst, "R7 cold reset without clock", int_rst, 1);
    chk(!bidir_en, "R9 cold path clears bidir_en", bidir_en, 0);
    repeat (5) @(negedge clk);
    pin_drv = 1'b1;
    wait_latch(k);
    chk(k == 4, "R7 cold release N+1", k, 4);
    mode_hi = 1'b1;
    wait_idle();
  endtask

  task automatic t_mode_drop();
    prescale_bypass = 1'b1;
    @(negedge clk);
    bidir_arm_wr = 1'b1;
    @(negedge clk);
    bidir_arm_wr = 1'b0;
    pin_drv = 1'b0;
    repeat (2) @(negedge clk);
    pin_drv = 1'b1;
    repeat (30) @(negedge clk);
    chk(pin_pull_low, "R5 pulling during internal phase", pin_pull_low, 1);
    mode_hi = 1'b0;
    #1;
    chk(!pin_pull_low && int_rst, "R7 mode drop releases pull at once", pin_pull_low, 0);
    @(negedge clk);
    mode_hi = 1'b1;
    wait_idle();
    chk(!int_rst && !bidir_en, "R7 recovered after mode drop", int_rst, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b1; pin_drv = 1'b1; mode_hi = 1'b1; prescale_bypass = 1'b1;
    access_done = 1'b0; bidir_arm_wr = 1'b0;
    clear_stats();
    t_por();
    t_glitch();
    t_warm(1'b0, 1'b0, 1'b1);
    t_warm(1'b1, 1'b0, 1'b0);
    t_warm(1'b0, 1'b1, 1'b1);
    t_extend();
    t_cold();
    t_mode_drop();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule